// File: doc/BRIEF.md
# Bandwidth-Limited Priority Core Activator

This block decides which cores waiting for test may start their next stretch of test patterns on a shared test bus. For every core it takes a ready flag, the number of test patterns still to be applied, a fixed-point defect probability, the current temperature and the bus bandwidth the core consumes. It also takes the bandwidth still free on the bus. A core is preferred when it has a lot of remaining work, a high chance of being defective and a low temperature. The block ranks the candidates by that preference and hands out bandwidth in rank order. It stops at the first candidate that does not fit.

A pass is requested with a valid/ready handshake on `start_valid`/`start_ready`. The requester holds `start_valid` high until `start_ready` is seen. All per-core inputs and the budget are captured in the cycle of acceptance and may change freely afterwards. While a pass runs, `start_ready` is low and requests are not taken. The pass examines one candidate per clock. It ends with a single-cycle `done` that carries the grant vector and the leftover budget. `done` has no back-pressure, so the result must be taken in that cycle, or later from the held outputs. Both outputs keep their values until the next request is accepted.

Top module: `core_grant_scheduler`

## Requirements
- R1: A core is a candidate only when its ready flag is 1 and its remaining pattern count is nonzero. A core that is not a candidate is never set in `activate`.
- R2: Candidates are examined in decreasing order of pattern count × defect probability ÷ temperature. Scores are compared exactly, by cross-multiplying at full width, with no rounding.
- R3: When two candidates have equal scores, the one with the lower core index is examined first.
- R4: A candidate is granted only when its bandwidth need is less than or equal to the remaining budget. On a grant, its bit in `activate` is set and the need is subtracted from the budget. `bw_left` shows the final budget.
- R5: When the examined candidate needs more than the remaining budget, the pass ends. No lower-ranked candidate is granted, even one that would fit.
- R6: The pass also ends when the budget is zero or no candidates remain. A candidate with zero need is not granted once the budget has reached zero.
- R7: A temperature input of 0 is treated as 1 when scores are compared.
- R8: `start_ready` equals the inverse of `busy`. After acceptance, `busy` stays high for exactly one cycle per grant plus one closing cycle. Requests presented while busy are ignored.
- R9: `done` is high for exactly one cycle, in the cycle after `busy` falls. `activate` and `bw_left` hold their values until the next accepted request, which clears `activate`.
- R10: After reset, `busy`, `done`, `activate` and `bw_left` are 0, and `start_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request for a pass |
| start_ready | output | 1 | Request can be accepted (idle) |
| core_rdy | input | N_CORES | Per-core ready-for-test flag |
| pat_rem | input | N_CORES*PAT_W | Remaining pattern count, core i at bits [i*PAT_W +: PAT_W] |
| defect_prob | input | N_CORES*PROB_W | Fixed-point defect probability per core |
| core_temp | input | N_CORES*TEMP_W | Current temperature code per core |
| bw_need | input | N_CORES*BW_W | Bus bandwidth each core needs |
| bw_total | input | BW_W | Budget free at the start of the pass |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass strobe |
| activate | output | N_CORES | Cores granted in the last pass |
| bw_left | output | BW_W | Budget remaining after the last pass |

## Verification
The bench sets up a ranking in which a low-ranked core would fit after the first misfit. A design that skips past the misfit would grant that core. It spends the budget to exactly zero while a zero-need candidate is still waiting. A design that does not stop on an empty budget would grant that candidate as well. Other cases use a zero temperature beside a hotter core with more work, where a literal zero would reverse the order, and full-scale operands that differ only in the lowest temperature bit, which a truncated product would rank wrongly. Equal scores check that ties go to the lower index. A fresh request held during a pass must not change the result. The length of each pass is compared with the grant count, which catches designs that examine more than one candidate per cycle or idle between them.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sched_st_e;
endpackage

// File: rtl/grant_elig.sv
module grant_elig #(
  parameter int N_CORES = 8,
  parameter int PAT_W   = 16,
  parameter int TEMP_W  = 8
) (
  input  logic [N_CORES-1:0]        rdy,
  input  logic [N_CORES*PAT_W-1:0]  pat_f,
  input  logic [N_CORES*TEMP_W-1:0] temp_f,
  output logic [N_CORES-1:0]        elig,
  output logic [N_CORES*TEMP_W-1:0] temp_clamped_f
);
  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    logic [PAT_W-1:0]  pat_i;
    logic [TEMP_W-1:0] tmp_i;
    assign pat_i = pat_f[i*PAT_W +: PAT_W];
    assign tmp_i = temp_f[i*TEMP_W +: TEMP_W];
    assign elig[i] = rdy[i] && (pat_i != '0);
    assign temp_clamped_f[i*TEMP_W +: TEMP_W] =
      (tmp_i == '0) ? TEMP_W'(1) : tmp_i;
  end
endmodule

// File: rtl/grant_prio_cmp.sv
module grant_prio_cmp #(
  parameter int PAT_W  = 16,
  parameter int PROB_W = 8,
  parameter int TEMP_W = 8
) (
  input  logic [PAT_W-1:0]  pat_a,
  input  logic [PROB_W-1:0] prob_a,
  input  logic [TEMP_W-1:0] temp_a,
  input  logic [PAT_W-1:0]  pat_b,
  input  logic [PROB_W-1:0] prob_b,
  input  logic [TEMP_W-1:0] temp_b,
  output logic              a_beats_b
);
  localparam int PROD_W = PAT_W + PROB_W + TEMP_W;
  logic [PROD_W-1:0] lhs, rhs;
  always_comb begin
    lhs = PROD_W'(pat_a) * PROD_W'(prob_a) * PROD_W'(temp_b);
    rhs = PROD_W'(pat_b) * PROD_W'(prob_b) * PROD_W'(temp_a);
    a_beats_b = lhs > rhs;
  end
endmodule

// File: rtl/grant_pick.sv
module grant_pick #(
  parameter int N_CORES = 8,
  parameter int PAT_W   = 16,
  parameter int PROB_W  = 8,
  parameter int TEMP_W  = 8,
  localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CORES-1:0]        pend,
  input  logic [N_CORES*PAT_W-1:0]  pat_f,
  input  logic [N_CORES*PROB_W-1:0] prob_f,
  input  logic [N_CORES*TEMP_W-1:0] temp_f,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);
  logic [IDX_W-1:0] best_idx [N_CORES+1];
  logic             best_vld [N_CORES+1];

  assign best_idx[0] = '0;
  assign best_vld[0] = 1'b0;

  for (genvar i = 0; i < N_CORES; i++) begin : g_stage
    logic beats, take;
    grant_prio_cmp #(.PAT_W(PAT_W), .PROB_W(PROB_W), .TEMP_W(TEMP_W)) u_cmp (
      .pat_a    (pat_f[i*PAT_W +: PAT_W]),
      .prob_a   (prob_f[i*PROB_W +: PROB_W]),
      .temp_a   (temp_f[i*TEMP_W +: TEMP_W]),
      .pat_b    (pat_f[best_idx[i]*PAT_W +: PAT_W]),
      .prob_b   (prob_f[best_idx[i]*PROB_W +: PROB_W]),
      .temp_b   (temp_f[best_idx[i]*TEMP_W +: TEMP_W]),
      .a_beats_b(beats)
    );
    // strict compare keeps the earlier (lower) index on a tie
    assign take = pend[i] && (!best_vld[i] || beats);
    assign best_idx[i+1] = take ? IDX_W'(i) : best_idx[i];
    assign best_vld[i+1] = take || best_vld[i];
  end

  assign any = best_vld[N_CORES];
  assign idx = best_idx[N_CORES];

  // R2
  pick_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> pend[idx]);
  // R6
  pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !any);
endmodule

// File: rtl/core_grant_scheduler.sv
module core_grant_scheduler #(
  parameter int N_CORES = 8,
  parameter int PAT_W   = 16,
  parameter int PROB_W  = 8,
  parameter int TEMP_W  = 8,
  parameter int BW_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_valid,
  output logic                      start_ready,
  input  logic [N_CORES-1:0]        core_rdy,
  input  logic [N_CORES*PAT_W-1:0]  pat_rem,
  input  logic [N_CORES*PROB_W-1:0] defect_prob,
  input  logic [N_CORES*TEMP_W-1:0] core_temp,
  input  logic [N_CORES*BW_W-1:0]   bw_need,
  input  logic [BW_W-1:0]           bw_total,
  output logic                      busy,
  output logic                      done,
  output logic [N_CORES-1:0]        activate,
  output logic [BW_W-1:0]           bw_left
);
  import sched_pkg::*;
  localparam int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1;

  sched_st_e                 st;
  logic [N_CORES-1:0]        pend, elig_lat, elig_now;
  logic [N_CORES*PAT_W-1:0]  pat_lat;
  logic [N_CORES*PROB_W-1:0] prob_lat;
  logic [N_CORES*TEMP_W-1:0] temp_lat, temp_now;
  logic [N_CORES*BW_W-1:0]   need_lat;
  logic [BW_W-1:0]           budget, total_lat, need_sel;
  logic                      pick_any, accept, fits;
  logic [IDX_W-1:0]          pick_idx;

  grant_elig #(.N_CORES(N_CORES), .PAT_W(PAT_W), .TEMP_W(TEMP_W)) u_elig (
    .rdy           (core_rdy),
    .pat_f         (pat_rem),
    .temp_f        (core_temp),
    .elig          (elig_now),
    .temp_clamped_f(temp_now)
  );

  grant_pick #(.N_CORES(N_CORES), .PAT_W(PAT_W), .PROB_W(PROB_W),
               .TEMP_W(TEMP_W)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend),
    .pat_f (pat_lat),
    .prob_f(prob_lat),
    .temp_f(temp_lat),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  assign busy        = (st == ST_RUN);
  assign start_ready = !busy;
  assign accept      = start_valid && start_ready;
  assign need_sel    = need_lat[pick_idx*BW_W +: BW_W];
  assign fits        = pick_any && (budget != '0) && (need_sel <= budget);
  assign bw_left     = budget;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      activate  <= '0;
      budget    <= '0;
      pend      <= '0;
      elig_lat  <= '0;
      total_lat <= '0;
      pat_lat   <= '0;
      prob_lat  <= '0;
      temp_lat  <= '0;
      need_lat  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st        <= ST_RUN;
        activate  <= '0;
        budget    <= bw_total;
        total_lat <= bw_total;
        pend      <= elig_now;
        elig_lat  <= elig_now;
        pat_lat   <= pat_rem;
        prob_lat  <= defect_prob;
        temp_lat  <= temp_now;
        need_lat  <= bw_need;
      end else if (st == ST_RUN) begin
        if (fits) begin
          activate[pick_idx] <= 1'b1;
          pend[pick_idx]     <= 1'b0;
          budget             <= budget - need_sel;
        end else begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      end
    end
  end

  // R1
  elig_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((activate & ~elig_lat) == '0));
  // R4
  budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bw_left <= total_lat));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  accept_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> busy);
  // R4
  grant_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (($past(activate) & ~activate) == '0));
endmodule

// File: tb/sim_core_grant_scheduler.sv
module sim_core_grant_scheduler;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]        rdy;
    logic [7:0][15:0]  pat;
    logic [7:0][7:0]   prob;
    logic [7:0][7:0]   temp;
    logic [7:0][7:0]   need;
    logic [7:0]        total;
    logic [7:0]        exp_act;
    logic [7:0]        exp_left;
  } vec_t;

  // per-core lists below are written core7 ... core0
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    // R2 R3 R4 R5: order 3,5,0 then core1 misfits; core7 would fit
    '{rdy:8'hFF, pat:{8{16'd10}}, prob:{8{8'd1}},
      temp:{8'd8,8'd8,8'd2,8'd8,8'd1,8'd8,8'd8,8'd4},
      need:{8'd1,{7{8'd3}}}, total:8'd10, exp_act:8'h29, exp_left:8'd1},
    // R1 R6: only 0,1,3 eligible; pass ends with none left
    '{rdy:8'h0F, pat:{16'd5,16'd5,16'd5,16'd5,16'd5,16'd0,16'd5,16'd5},
      prob:{8{8'd2}}, temp:{8{8'd10}}, need:{8{8'd1}},
      total:8'd20, exp_act:8'h0B, exp_left:8'd17},
    // R3 R6: equal scores, budget hits zero before zero-need core2
    '{rdy:8'hFF, pat:{8{16'd1}}, prob:{8{8'd1}}, temp:{8{8'd1}},
      need:{8'd4,8'd4,8'd4,8'd4,8'd4,8'd0,8'd4,8'd4},
      total:8'd8, exp_act:8'h03, exp_left:8'd0},
    // R7: core1 temp 0 counts as 1, core0 (2 patterns) ranks first
    '{rdy:8'h03, pat:{{6{16'd1}},16'd1,16'd2}, prob:{8{8'd1}},
      temp:{{6{8'd1}},8'd0,8'd1}, need:{8{8'd5}},
      total:8'd5, exp_act:8'h01, exp_left:8'd0},
    // R5: top core does not fit, nothing granted
    '{rdy:8'hFF, pat:{{7{16'd1}},16'd100}, prob:{{7{8'd1}},8'd100},
      temp:{{7{8'd200}},8'd1}, need:{{7{8'd1}},8'd9},
      total:8'd8, exp_act:8'h00, exp_left:8'd8},
    // R2: full-scale operands, core6 slightly cooler than core2
    '{rdy:8'h44, pat:{8{16'hFFFF}}, prob:{8{8'hFF}},
      temp:{8'd1,8'hFE,8'd1,8'd1,8'd1,8'hFF,8'd1,8'd1},
      need:{8{8'd5}}, total:8'd5, exp_act:8'h40, exp_left:8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic start_ready, busy, done;
  logic [7:0]   core_rdy = '0;
  logic [127:0] pat_rem = '0;
  logic [63:0]  defect_prob = '0, core_temp = '0, bw_need = '0;
  logic [7:0]   bw_total = '0;
  logic [7:0]   activate, bw_left;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_grant_scheduler u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_ready(start_ready), .core_rdy(core_rdy), .pat_rem(pat_rem),
    .defect_prob(defect_prob), .core_temp(core_temp), .bw_need(bw_need),
    .bw_total(bw_total), .busy(busy), .done(done), .activate(activate),
    .bw_left(bw_left)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    core_rdy    = v.rdy;
    pat_rem     = v.pat;
    defect_prob = v.prob;
    core_temp   = v.temp;
    bw_need     = v.need;
    bw_total    = v.total;
  endtask

  task automatic run_vec(input vec_t v, input bit disturb);
    int nb = 0;
    int waits = 0;
    @(negedge clk);
    load(v);
    start_valid = 1'b1;
    @(negedge clk);
    if (disturb) load(VECS[4]);   // R8: new request while busy
    else start_valid = 1'b0;
    while (!done && waits < 100) begin
      if (busy) nb++;
      @(negedge clk);
      waits++;
      if (waits == 2) start_valid = 1'b0;
    end
    start_valid = 1'b0;
    if (waits >= 100) chk("R9 done timeout", 0, 1);
    chk("R2 R4 activate", int'(activate), int'(v.exp_act));
    chk("R4 bw_left", int'(bw_left), int'(v.exp_left));
    chk("R8 busy cycles", nb, $countones(v.exp_act) + 1);
    @(negedge clk);
    chk("R9 done single", int'(done), 0);
    chk("R9 activate held", int'(activate), int'(v.exp_act));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 activate", int'(activate), 0);
    chk("R10 bw_left", int'(bw_left), 0);
    chk("R10 start_ready", int'(start_ready), 1);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);
    // R8: request held during the pass must not disturb the result
    run_vec(VECS[0], 1'b1);
    // R8: no restart after the disturbed pass
    @(negedge clk);
    chk("R8 idle after pass", int'(busy), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule